// File: doc/BRIEF.md
# I2C Target Transmitter with Event Status Codes

This block is the target (slave) side of an I2C bus for read transfers. It watches the bus and collects the 7-bit address that follows each START. When that address is its own and the direction bit asks for a read, it acknowledges the address. It then sends bytes that the host logic has placed in its data register, most significant bit first. Every bus event that needs the host's attention raises an interrupt flag and shows an 8-bit status code. While that flag is up, the block stretches the clock by holding SCL low. The host reads the code, loads the next byte if one is needed, and clears the flag to let the transfer go on.

The host can mark a byte as the final one by dropping the acknowledge-enable input before it clears the flag. After that byte the block reports the master's answer, leaves the transfer and releases SDA. A master that keeps reading therefore sees only ones. When an address with the write bit, or the general call address, is acknowledged, the block only reports it: it does not receive any data. Both bus lines are open-drain. They are sampled and synchronised on a system clock that runs much faster than SCL.

Top module: `i2c_tgt_tx`

## Requirements
- R1: After reset, and whenever `cfg_en` is low, `irq_flag` is 0, `status_code` is 0xF8, `wr_coll` is 0 and neither line is driven. Dropping `cfg_en` during a pending event clears that event at once.
- R2: When the byte after START has bits 7:1 equal to `cfg_addr[7:1]` and bit 0 = 1, and `cfg_ack_en` is 1, SDA is pulled low for the ninth clock. After that clock falls, `irq_flag` rises with `status_code` 0xA8.
- R3: An address byte that matches neither the own address nor an enabled general call is not acknowledged and raises no flag. Byte 0x00 is acknowledged only when `cfg_addr[0]` is 1, and then gives status 0x70. The own address with bit 0 = 0 is acknowledged and gives status 0x60.
- R4: While `irq_flag` is 1, SCL is held low. The flag falls only on a `host_flag_clr` pulse or on disable, and SCL is released after that.
- R5: Data bytes go out MSB first, SDA changing only while SCL is low. After a byte that the master acknowledged, with `cfg_ack_en` 1 when the byte was started, the status is 0xB8.
- R6: A byte that the master answers with NACK gives status 0xC0. After the flag is cleared the target leaves the transfer, and further reads return 0xFF.
- R7: A byte started (flag cleared) while `cfg_ack_en` is 0 is the last one. The master's ACK gives status 0xC8 and its NACK gives 0xC0. After the flag is cleared, SDA stays released, so later bytes read 0xFF and raise no flag.
- R8: While `cfg_ack_en` is 0, the own address is not acknowledged. Once it is 1 again, the next START, repeated or not, is matched as normal.
- R9: A `host_wr_data` pulse while `irq_flag` is 0 sets `wr_coll` and leaves the byte to be sent unchanged. A write while the flag is 1 loads the byte and clears `wr_coll`.
- R10: A STOP or a repeated START in any phase except a pending event returns the block to address matching, and no flag is raised.
- R11: Whenever `irq_flag` is 0, `status_code` reads 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Block enable; 0 clears all state |
| cfg_ack_en | input | 1 | Acknowledge enable / last-byte marker when 0 |
| cfg_addr | input | 8 | Own address in 7:1, general call enable in bit 0 |
| host_wr_data | input | 1 | One-cycle strobe writing `host_data` to the data register |
| host_data | input | 8 | Byte to send next |
| host_flag_clr | input | 1 | One-cycle strobe clearing the interrupt flag |
| irq_flag | output | 1 | Event pending |
| status_code | output | 8 | Code of the pending event, 0xF8 when none |
| wr_coll | output | 1 | Data register written while no event was pending |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench plays the bus master and checks that bytes arrive bit-exact and MSB first. A design that shifted the wrong way or lost a bit at the ninth clock would send corrupted data. It checks the last-byte rule with both master answers. A design that latched the acknowledge-enable at the wrong moment would report 0xB8 where 0xC8 is due, or would keep driving SDA after its last byte. It also checks the address filter: a wrong address, a general call with the enable bit low and high, and an own address while acknowledge is off followed by a repeated START. A loose filter acknowledges foreign traffic, and a filter that fails to resume stays deaf. Finally it checks a collided data write, and a STOP or repeated START in mid-address. A design that got these wrong would send the collided byte or would raise a spurious event.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [7:0] SC_SLA_RD  = 8'hA8;
  localparam logic [7:0] SC_DAT_ACK = 8'hB8;
  localparam logic [7:0] SC_DAT_NAK = 8'hC0;
  localparam logic [7:0] SC_END_ACK = 8'hC8;
  localparam logic [7:0] SC_SLA_WR  = 8'h60;
  localparam logic [7:0] SC_GCALL   = 8'h70;
  localparam logic [7:0] SC_NONE    = 8'hF8;

  typedef enum logic [2:0] {
    T_IDLE,   // not addressed, waiting for START
    T_ADDR,   // collecting address byte
    T_ACKW,   // matched, waiting for SCL low to drive ACK
    T_ACKD,   // driving ACK during ninth clock
    T_HOLD,   // event pending, SCL stretched
    T_TXB,    // shifting a data byte out
    T_TXA     // master acknowledge slot
  } tgt_state_t;

  typedef enum logic {
    GO_IDLE,
    GO_SEND
  } resume_t;

  function automatic logic own_match(input logic [BYTE_W-1:0] cfg,
                                     input logic [BYTE_W-1:0] rx);
    return (rx[BYTE_W-1:1] == cfg[BYTE_W-1:1]) && (cfg[BYTE_W-1:1] != '0);
  endfunction

  function automatic logic gcall_match(input logic [BYTE_W-1:0] cfg,
                                       input logic [BYTE_W-1:0] rx);
    return cfg[0] && (rx == '0);
  endfunction

  function automatic logic [7:0] byte_done_code(input logic final_byte,
                                                input logic master_ack);
    if (!master_ack)     return SC_DAT_NAK;
    else if (final_byte) return SC_END_ACK;
    else                 return SC_DAT_ACK;
  endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_lvl;
      sda_d <= sda_lvl;
    end
  end

  assign scl_lvl  = scl_pipe[STAGES-1];
  assign sda_lvl  = sda_pipe[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_d;
  assign scl_fall = ~scl_lvl & scl_d;
  assign ev_start = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign ev_stop  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_val,
  input  logic              pending,
  output logic [BYTE_W-1:0] data_q,
  output logic              coll_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      coll_q <= 1'b0;
    end else if (!en) begin
      data_q <= '0;
      coll_q <= 1'b0;
    end else if (wr_stb) begin
      if (pending) begin
        data_q <= wr_val;
        coll_q <= 1'b0;
      end else begin
        coll_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ack_en,
  input  logic [BYTE_W-1:0] own_cfg,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              flag_clr,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              pending,
  output logic [7:0]        code_q,
  output logic              sda_drive
);

  tgt_state_t        st;
  resume_t           resume;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bitn;
  logic              final_q;
  logic              mack_q;
  logic [BYTE_W-1:0] addr_byte;
  logic              last_bit;
  logic              bus_event;

  assign addr_byte = {shreg[BYTE_W-2:0], sda_lvl};
  assign last_bit  = (bitn == CNT_W'(BYTE_W-1));
  assign bus_event = (ev_start || ev_stop) && (st != T_HOLD);
  assign pending   = (st == T_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= T_IDLE;
      resume    <= GO_IDLE;
      shreg     <= '0;
      bitn      <= '0;
      final_q   <= 1'b0;
      mack_q    <= 1'b0;
      code_q    <= SC_NONE;
      sda_drive <= 1'b0;
    end else if (!en) begin
      st        <= T_IDLE;
      resume    <= GO_IDLE;
      shreg     <= '0;
      bitn      <= '0;
      final_q   <= 1'b0;
      mack_q    <= 1'b0;
      code_q    <= SC_NONE;
      sda_drive <= 1'b0;
    end else if (bus_event) begin
      st        <= ev_start ? T_ADDR : T_IDLE;
      bitn      <= '0;
      sda_drive <= 1'b0;
    end else begin
      unique case (st)
        T_IDLE: ;
        T_ADDR: begin
          if (scl_rise) begin
            shreg <= addr_byte;
            if (last_bit) begin
              bitn <= '0;
              if (ack_en && own_match(own_cfg, addr_byte)) begin
                st     <= T_ACKW;
                code_q <= addr_byte[0] ? SC_SLA_RD : SC_SLA_WR;
                resume <= addr_byte[0] ? GO_SEND : GO_IDLE;
              end else if (ack_en && gcall_match(own_cfg, addr_byte)) begin
                st     <= T_ACKW;
                code_q <= SC_GCALL;
                resume <= GO_IDLE;
              end else begin
                st <= T_IDLE;
              end
            end else begin
              bitn <= bitn + 1'b1;
            end
          end
        end
        T_ACKW: begin
          if (scl_fall) begin
            st        <= T_ACKD;
            sda_drive <= 1'b1;
          end
        end
        T_ACKD: begin
          if (scl_fall) begin
            st        <= T_HOLD;
            sda_drive <= 1'b0;
          end
        end
        T_HOLD: begin
          if (flag_clr) begin
            if (resume == GO_SEND) begin
              st        <= T_TXB;
              shreg     <= tx_byte;
              bitn      <= '0;
              final_q   <= ~ack_en;
              sda_drive <= ~tx_byte[BYTE_W-1];
            end else begin
              st        <= T_IDLE;
              sda_drive <= 1'b0;
            end
          end
        end
        T_TXB: begin
          if (scl_fall) begin
            if (last_bit) begin
              st        <= T_TXA;
              sda_drive <= 1'b0;
            end else begin
              shreg     <= {shreg[BYTE_W-2:0], 1'b0};
              sda_drive <= ~shreg[BYTE_W-2];
              bitn      <= bitn + 1'b1;
            end
          end
        end
        T_TXA: begin
          if (scl_rise) begin
            mack_q <= ~sda_lvl;
          end else if (scl_fall) begin
            st     <= T_HOLD;
            code_q <= byte_done_code(final_q, mack_q);
            resume <= (mack_q && !final_q) ? GO_SEND : GO_IDLE;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_tgt_tx.sv
module i2c_tgt_tx
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_en,
  input  logic       cfg_ack_en,
  input  logic [7:0] cfg_addr,
  input  logic       host_wr_data,
  input  logic [7:0] host_data,
  input  logic       host_flag_clr,
  output logic       irq_flag,
  output logic [7:0] status_code,
  output logic       wr_coll,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);

  logic              scl_lvl, sda_lvl, scl_rise, scl_fall, ev_start, ev_stop;
  logic              pending;
  logic [7:0]        code_q;
  logic [BYTE_W-1:0] data_q;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .ev_start (ev_start),
    .ev_stop  (ev_stop)
  );

  i2c_tgt_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg_en),
    .wr_stb  (host_wr_data),
    .wr_val  (host_data),
    .pending (pending),
    .data_q  (data_q),
    .coll_q  (wr_coll)
  );

  i2c_tgt_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .ack_en    (cfg_ack_en),
    .own_cfg   (cfg_addr),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .flag_clr  (host_flag_clr),
    .tx_byte   (data_q),
    .pending   (pending),
    .code_q    (code_q),
    .sda_drive (sda_oe)
  );

  assign irq_flag    = pending;
  assign scl_oe      = pending;
  assign status_code = pending ? code_q : SC_NONE;

endmodule

// File: rtl/i2c_tgt_tx_chk.sv
module i2c_tgt_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_en,
  input logic       host_wr_data,
  input logic       host_flag_clr,
  input logic       irq_flag,
  input logic [7:0] status_code,
  input logic       wr_coll,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       scl_lvl,
  input logic       ev_start,
  input logic       ev_stop
);

  p_disable_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (!sda_oe && !scl_oe && !irq_flag && status_code == 8'hF8));

  p_event_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> (status_code == 8'hA8 || status_code == 8'hB8 ||
                         status_code == 8'hC0 || status_code == 8'hC8 ||
                         status_code == 8'h60 || status_code == 8'h70));

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !host_flag_clr && cfg_en) |=> irq_flag);

  p_sda_when_low_r5: assert property (@(posedge clk) disable iff (!rst_n || !cfg_en)
    (!$stable(sda_oe) && !$past(ev_start) && !$past(ev_stop)) |-> !$past(scl_lvl));

  p_coll_flag_r9: assert property (@(posedge clk) disable iff (!rst_n || !cfg_en)
    (host_wr_data && !irq_flag) |=> wr_coll);

endmodule

bind i2c_tgt_tx i2c_tgt_tx_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_en        (cfg_en),
  .host_wr_data  (host_wr_data),
  .host_flag_clr (host_flag_clr),
  .irq_flag      (irq_flag),
  .status_code   (status_code),
  .wr_coll       (wr_coll),
  .sda_oe        (sda_oe),
  .scl_oe        (scl_oe),
  .scl_lvl       (scl_lvl),
  .ev_start      (ev_start),
  .ev_stop       (ev_stop)
);

// File: tb/sim_i2c_tgt_tx.sv
module sim_i2c_tgt_tx;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 8;
  localparam int WDOG       = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b1;
  logic       cfg_ack_en = 1'b1;
  logic [7:0] cfg_addr = 8'h52;
  logic       host_wr_data = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic       host_flag_clr = 1'b0;
  logic       irq_flag, wr_coll, scl_oe, sda_oe;
  logic [7:0] status_code;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_bus, sda_bus;
  int         n_chk = 0, n_bad = 0;
  bit         mon_on = 1'b0;

  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_tgt_tx u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_ack_en(cfg_ack_en),
    .cfg_addr(cfg_addr), .host_wr_data(host_wr_data), .host_data(host_data),
    .host_flag_clr(host_flag_clr), .irq_flag(irq_flag), .status_code(status_code),
    .wr_coll(wr_coll), .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; idle(QTR);
    scl_m = 1'b1; idle(QTR);
    sda_m = 1'b0; idle(QTR);
    scl_m = 1'b0; idle(QTR);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; idle(QTR);
    scl_m = 1'b1; idle(QTR);
    sda_m = 1'b1; idle(QTR);
  endtask

  task automatic bus_bit(input logic b, output logic r);
    sda_m = b; idle(QTR);
    scl_m = 1'b1;
    while (scl_bus !== 1'b1) @(negedge clk);
    idle(QTR);
    r = sda_bus;
    scl_m = 1'b0; idle(QTR);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_bit);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
    bus_bit(1'b1, ack_bit);
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, r);
      d[i] = r;
    end
    bus_bit(~give_ack, r);
  endtask

  task automatic host_write(input logic [7:0] d);
    host_data = d; host_wr_data = 1'b1;
    @(negedge clk);
    host_wr_data = 1'b0;
  endtask

  task automatic host_clear;
    host_flag_clr = 1'b1;
    @(negedge clk);
    host_flag_clr = 1'b0;
  endtask

  // per-clock reference relations: R4 stretch follows the flag, R11 idle code
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      check(scl_oe == irq_flag, "R4 scl hold vs flag", scl_oe, irq_flag);
      check(irq_flag || status_code == 8'hF8, "R11 idle status", status_code, 8'hF8);
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", WDOG);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic       a;
    logic [7:0] d;
    idle(5);
    rst_n = 1'b1;
    idle(3);
    mon_on = 1'b1;

    // R1 reset state
    check(irq_flag == 1'b0, "R1 flag after reset", irq_flag, 0);
    check(status_code == 8'hF8, "R1 status after reset", status_code, 8'hF8);
    check(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    check(wr_coll == 1'b0, "R1 wr_coll after reset", wr_coll, 0);

    // R9 write while no event pending
    host_write(8'h11);
    check(wr_coll == 1'b1, "R9 collision set", wr_coll, 1);

    // R2 own address read
    bus_start;
    send_byte(8'h53, a);
    check(a == 1'b0, "R2 address ACK", a, 0);
    check(irq_flag == 1'b1, "R2 flag raised", irq_flag, 1);
    check(status_code == 8'hA8, "R2 status", status_code, 8'hA8);
    idle(20);
    check(scl_bus == 1'b0, "R4 SCL stretched", scl_bus, 0);
    host_clear;
    idle(2);
    check(scl_oe == 1'b0, "R4 SCL released", scl_oe, 0);
    read_byte(1'b1, d);
    check(d == 8'h00, "R9 collided write not sent", d, 8'h00);
    check(status_code == 8'hB8, "R5 status after ACK", status_code, 8'hB8);
    host_write(8'hA5);
    check(wr_coll == 1'b0, "R9 collision cleared", wr_coll, 0);
    host_clear;
    read_byte(1'b1, d);
    check(d == 8'hA5, "R5 byte MSB first", d, 8'hA5);
    check(status_code == 8'hB8, "R5 status second byte", status_code, 8'hB8);

    // R7 last byte with master ACK
    host_write(8'h3C);
    cfg_ack_en = 1'b0;
    host_clear;
    read_byte(1'b1, d);
    check(d == 8'h3C, "R7 last byte data", d, 8'h3C);
    check(status_code == 8'hC8, "R7 status last ACKed", status_code, 8'hC8);
    host_clear;
    cfg_ack_en = 1'b1;
    read_byte(1'b1, d);
    check(d == 8'hFF, "R7 reads ones after last", d, 8'hFF);
    check(irq_flag == 1'b0, "R7 no flag after last", irq_flag, 0);
    bus_stop;

    // R7 last byte with master NACK
    bus_start;
    send_byte(8'h53, a);
    host_write(8'h5A);
    cfg_ack_en = 1'b0;
    host_clear;
    read_byte(1'b0, d);
    check(status_code == 8'hC0, "R7 status last NACKed", status_code, 8'hC0);
    host_clear;
    cfg_ack_en = 1'b1;
    bus_stop;

    // R6 NACK on ordinary byte
    bus_start;
    send_byte(8'h53, a);
    host_write(8'h81);
    host_clear;
    read_byte(1'b0, d);
    check(d == 8'h81, "R6 byte data", d, 8'h81);
    check(status_code == 8'hC0, "R6 status NACK", status_code, 8'hC0);
    host_clear;
    read_byte(1'b1, d);
    check(d == 8'hFF, "R6 ones after NACK", d, 8'hFF);
    check(irq_flag == 1'b0, "R6 no flag after NACK", irq_flag, 0);
    bus_stop;

    // R3 foreign address
    bus_start;
    send_byte(8'h55, a);
    check(a == 1'b1, "R3 foreign not ACKed", a, 1);
    check(irq_flag == 1'b0, "R3 foreign no flag", irq_flag, 0);
    bus_stop;

    // R3 general call disabled then enabled
    bus_start;
    send_byte(8'h00, a);
    check(a == 1'b1, "R3 general call ignored", a, 1);
    bus_stop;
    cfg_addr = 8'h53;
    bus_start;
    send_byte(8'h00, a);
    check(a == 1'b0, "R3 general call ACK", a, 0);
    check(status_code == 8'h70, "R3 general call status", status_code, 8'h70);
    host_clear;
    bus_stop;

    // R3 own address write direction
    bus_start;
    send_byte(8'h52, a);
    check(a == 1'b0, "R3 write address ACK", a, 0);
    check(status_code == 8'h60, "R3 write address status", status_code, 8'h60);
    host_clear;
    bus_stop;

    // R8 acknowledge off, then repeated START
    cfg_ack_en = 1'b0;
    bus_start;
    send_byte(8'h53, a);
    check(a == 1'b1, "R8 no ACK when disabled", a, 1);
    check(irq_flag == 1'b0, "R8 no flag when disabled", irq_flag, 0);
    cfg_ack_en = 1'b1;
    bus_start;
    send_byte(8'h53, a);
    check(a == 1'b0, "R8 ACK after re-enable", a, 0);
    check(status_code == 8'hA8, "R8 status after re-enable", status_code, 8'hA8);

    // R1 disable during pending event
    cfg_en = 1'b0;
    idle(2);
    check(irq_flag == 1'b0 && scl_oe == 1'b0, "R1 disable clears event",
          {irq_flag, scl_oe}, 0);
    check(status_code == 8'hF8, "R1 disable status", status_code, 8'hF8);
    cfg_en = 1'b1;
    idle(2);
    bus_stop;

    // R10 STOP in mid-address
    bus_start;
    for (int i = 7; i >= 4; i--) bus_bit(i[0], a);
    bus_stop;
    bus_start;
    bus_bit(1'b0, a);
    bus_bit(1'b1, a);
    bus_start;
    for (int i = 0; i < 5; i++) bus_bit(1'b1, a);
    bus_stop;
    check(irq_flag == 1'b0 && sda_oe == 1'b0, "R10 STOP leaves idle",
          {irq_flag, sda_oe}, 0);

    // R10 repeated START in mid-address then full match
    bus_start;
    bus_bit(1'b0, a);
    bus_bit(1'b1, a);
    bus_bit(1'b0, a);
    bus_start;
    send_byte(8'h53, a);
    check(a == 1'b0, "R10 match after repeated START", a, 0);
    check(status_code == 8'hA8, "R10 status after repeated START", status_code, 8'hA8);
    host_write(8'hC3);
    host_clear;
    bus_stop;
    idle(4);
    check(irq_flag == 1'b0 && sda_oe == 1'b0, "R10 STOP during send",
          {irq_flag, sda_oe}, 0);

    idle(10);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule